// File: doc/BRIEF.md
# ATM Cell CRC-10 Inserter

This block sits in the transmit byte stream of a cell processor. It handles raw cells, meaning cells sent without an AAL5 trailer. Each cell is 53 bytes: a 5-byte header, a payload of 46 whole bytes plus 6 bits, and a 10-bit check field at the end. When the per-cell enable is set, the block computes a CRC-10 over the payload bits and writes it over the last 10 bits of the cell. When the enable is clear, the cell passes through unchanged. The header is never included in the CRC and is never modified.

Bytes arrive on a valid/ready interface. A start-of-cell marker and a CRC-enable sideband travel with the bytes. The output uses the same kind of interface. The data path is a pure forwarding path: `out_valid` follows `in_valid` and `in_ready` follows `out_ready`, so a stall downstream freezes the block with no loss of data.

A state machine tracks the position of each byte within its cell. The states and their transitions on each accepted byte are:
- `ST_HUNT` waits for a byte that carries the marker. That byte is header byte 0, and it moves the machine to `ST_HEADER`.
- `ST_HEADER` covers bytes 1 to 4, then moves to `ST_PAYLOAD`.
- `ST_PAYLOAD` covers bytes 5 to 50, then moves to `ST_CRC_HI`.
- `ST_CRC_HI` covers byte 51, then moves to `ST_CRC_LO`.
- `ST_CRC_LO` covers byte 52, then returns to `ST_HUNT`.

Top module: `cell_crc10_inserter`

## Requirements
- R1: After reset the block is in `ST_HUNT`. A byte accepted there without the start marker is forwarded unchanged and does not begin a cell.
- R2: `out_valid` equals `in_valid`, `out_soc` equals `in_soc`, and `in_ready` equals `out_ready`. During reset `out_valid` is 0 while `in_valid` is 0.
- R3: Header bytes 0 to 4 of a cell are always forwarded unchanged.
- R4: Payload bytes 5 to 50 are always forwarded unchanged.
- R5: With the enable set, byte 51 carries its input bits 7..2 followed by CRC bits 9..8, and byte 52 carries CRC bits 7..0. The input bits of byte 52 and bits 1..0 of byte 51 are discarded.
- R6: The CRC uses G(x) = x^10 + x^9 + x^5 + x^4 + x + 1 (mask 0x233). It starts from all zeros at the first payload bit and takes the 374 payload bits MSB first within each byte. A CRC run over output bytes 5 to 52 therefore leaves a zero remainder.
- R7: With the enable clear, all 53 bytes of the cell are forwarded unchanged.
- R8: The enable is sampled only on the byte that carries the start marker. Changes to `in_crc_en` during the rest of the cell have no effect.
- R9: A cycle without a handshake (`in_valid` && `out_ready`) leaves the byte position and the CRC state unchanged, so any pattern of stalls gives the same output bytes.
- R10: After byte 52 the machine returns to `ST_HUNT`, so cells may follow back to back with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can accept the input byte |
| in_data | input | 8 | Input cell byte |
| in_soc | input | 1 | Marks byte 0 of a cell |
| in_crc_en | input | 1 | CRC insertion enable, sampled with the marker |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Output cell byte |
| out_soc | output | 1 | Marks byte 0 of an output cell |

## Verification
The assertions assume that the start marker is only ever presented while the block is hunting. In other words, cells are always sent whole: 53 bytes, with the marker on the first byte only. The stimulus enforces this by building each cell as a complete 53-byte unit, with the marker on byte 0 alone. The only bytes sent without a marker outside a cell are the stray bytes sent right after reset. Random gaps on `in_valid` and random drops of `out_ready` are applied inside each cell. These cover stalls at every byte position without ever breaking the cell framing.

// File: rtl/cc10_pkg.sv
package cc10_pkg;

    localparam int BYTE_W = 8;
    localparam int CRC_W  = 10;
    localparam logic [CRC_W-1:0] CRC_POLY = 10'h233;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_HEADER,
        ST_PAYLOAD,
        ST_CRC_HI,
        ST_CRC_LO
    } cc10_state_e;

    typedef struct packed {
        logic step;    // advance CRC on this byte
        logic seed;    // start from zero
        logic six;     // only bits 7..2 count
        logic ins_hi;  // merge CRC[9:8] into byte
        logic ins_lo;  // replace byte with CRC[7:0]
    } cc10_ctrl_t;

    // MSB-first update over one byte; with six set the two low bits are skipped
    function automatic logic [CRC_W-1:0] crc10_byte(input logic [CRC_W-1:0] c_in,
                                                    input logic [BYTE_W-1:0] d,
                                                    input logic six);
        logic [CRC_W-1:0] c;
        logic fb;
        c = c_in;
        for (int i = BYTE_W - 1; i >= 0; i--) begin
            if (!(six && i < 2)) begin
                fb = c[CRC_W-1] ^ d[i];
                c  = {c[CRC_W-2:0], 1'b0};
                if (fb) c = c ^ CRC_POLY;
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/cc10_crc_unit.sv
module cc10_crc_unit
    import cc10_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              seed,
    input  logic              six,
    input  logic [BYTE_W-1:0] data,
    output logic [CRC_W-1:0]  crc_q,
    output logic [CRC_W-1:0]  crc_nx
);

    logic [CRC_W-1:0] base;

    always_comb begin
        base   = seed ? '0 : crc_q;
        crc_nx = crc10_byte(base, data, six);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= '0;
        end else if (step) begin
            crc_q <= crc_nx;
        end
    end

endmodule

// File: rtl/cc10_cell_fsm.sv
module cc10_cell_fsm
    import cc10_pkg::*;
#(
    parameter int CELL_BYTES = 53,
    parameter int HDR_BYTES  = 5,
    parameter int POS_W      = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic             soc,
    input  logic             crc_en,
    output cc10_state_e      state_q,
    output logic [POS_W-1:0] pos_q,
    output logic             en_q,
    output cc10_ctrl_t       ctrl
);

    localparam logic [POS_W-1:0] LAST_HDR  = POS_W'(HDR_BYTES - 1);
    localparam logic [POS_W-1:0] FIRST_PAY = POS_W'(HDR_BYTES);
    localparam logic [POS_W-1:0] LAST_PAY  = POS_W'(CELL_BYTES - 3);

    cc10_state_e      state_d;
    logic [POS_W-1:0] pos_d;
    logic             en_d;

    // next state and state register
    always_comb begin
        state_d = state_q;
        pos_d   = pos_q;
        en_d    = en_q;
        if (fire) begin
            unique case (state_q)
                ST_HUNT: begin
                    if (soc) begin
                        state_d = ST_HEADER;
                        pos_d   = POS_W'(1);
                        en_d    = crc_en;
                    end
                end
                ST_HEADER: begin
                    pos_d = pos_q + 1'b1;
                    if (pos_q == LAST_HDR) state_d = ST_PAYLOAD;
                end
                ST_PAYLOAD: begin
                    pos_d = pos_q + 1'b1;
                    if (pos_q == LAST_PAY) state_d = ST_CRC_HI;
                end
                ST_CRC_HI: begin
                    pos_d   = pos_q + 1'b1;
                    state_d = ST_CRC_LO;
                end
                ST_CRC_LO: begin
                    pos_d   = '0;
                    state_d = ST_HUNT;
                end
                default: begin
                    pos_d   = '0;
                    state_d = ST_HUNT;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            pos_q   <= '0;
            en_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
            en_q    <= en_d;
        end
    end

    // outputs decoded from the current state
    always_comb begin
        ctrl = '0;
        unique case (state_q)
            ST_HUNT, ST_HEADER: ;
            ST_PAYLOAD: begin
                ctrl.step = fire;
                ctrl.seed = (pos_q == FIRST_PAY);
            end
            ST_CRC_HI: begin
                ctrl.step   = fire;
                ctrl.six    = 1'b1;
                ctrl.ins_hi = en_q;
            end
            ST_CRC_LO: begin
                ctrl.ins_lo = en_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/cell_crc10_inserter.sv
module cell_crc10_inserter
    import cc10_pkg::*;
#(
    parameter int CELL_BYTES = 53,
    parameter int HDR_BYTES  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_soc,
    input  logic              in_crc_en,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_soc
);

    localparam int POS_W = $clog2(CELL_BYTES);

    cc10_state_e      state_q;
    logic [POS_W-1:0] pos_q;
    logic             en_q;
    cc10_ctrl_t       ctrl;
    logic             fire;
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_nx;

    assign fire      = in_valid && out_ready;
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_soc   = in_soc;

    cc10_cell_fsm #(
        .CELL_BYTES (CELL_BYTES),
        .HDR_BYTES  (HDR_BYTES),
        .POS_W      (POS_W)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fire),
        .soc     (in_soc),
        .crc_en  (in_crc_en),
        .state_q (state_q),
        .pos_q   (pos_q),
        .en_q    (en_q),
        .ctrl    (ctrl)
    );

    cc10_crc_unit u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (ctrl.step),
        .seed   (ctrl.seed),
        .six    (ctrl.six),
        .data   (in_data),
        .crc_q  (crc_q),
        .crc_nx (crc_nx)
    );

    always_comb begin
        if (ctrl.ins_hi) begin
            out_data = {in_data[BYTE_W-1:2], crc_nx[CRC_W-1:CRC_W-2]};
        end else if (ctrl.ins_lo) begin
            out_data = crc_q[BYTE_W-1:0];
        end else begin
            out_data = in_data;
        end
    end

endmodule

// File: rtl/cc10_checker.sv
module cc10_checker
    import cc10_pkg::*;
#(
    parameter int CELL_BYTES = 53,
    parameter int POS_W      = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [BYTE_W-1:0] in_data,
    input logic              in_soc,
    input logic              out_ready,
    input logic [BYTE_W-1:0] out_data,
    input cc10_state_e       state_q,
    input logic [POS_W-1:0]  pos_q,
    input logic              en_q
);

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && out_ready) |=> ($stable(state_q) && $stable(pos_q))); // R9
    AST_HDR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (state_q == ST_HUNT || state_q == ST_HEADER)) |-> out_data == in_data); // R3
    AST_PAY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && state_q == ST_PAYLOAD) |-> out_data == in_data); // R4
    AST_OFF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !en_q) |-> out_data == in_data); // R7
    AST_TAIL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && state_q == ST_CRC_HI) |-> out_data[7:2] == in_data[7:2]); // R5
    AST_EN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_HUNT) |=> $stable(en_q)); // R8
    AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pos_q) < CELL_BYTES); // R10
    AST_SOC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_soc) |-> state_q == ST_HUNT); // R10
    AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && out_ready && state_q == ST_CRC_LO) |=> (state_q == ST_HUNT && pos_q == '0)); // R10

endmodule

bind cell_crc10_inserter cc10_checker #(
    .CELL_BYTES (CELL_BYTES),
    .POS_W      ($clog2(CELL_BYTES))
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_soc    (in_soc),
    .out_ready (out_ready),
    .out_data  (out_data),
    .state_q   (state_q),
    .pos_q     (pos_q),
    .en_q      (en_q)
);

// File: tb/test_cell_crc10_inserter.sv
`timescale 1ns/1ps
module test_cell_crc10_inserter;

    localparam int CELL = 53;
    localparam int HDR  = 5;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid, in_ready, in_soc, in_crc_en;
    logic [7:0] in_data;
    logic       out_valid, out_ready, out_soc;
    logic [7:0] out_data;

    int n_run  = 0;
    int n_fail = 0;
    int stall_pct = 25;
    bit done = 1'b0;

    logic [7:0] cell_in  [CELL];
    logic [7:0] cell_out [CELL];

    always #2 clk = ~clk;

    cell_crc10_inserter i_cell_crc10_inserter (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_soc(in_soc), .in_crc_en(in_crc_en),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_soc(out_soc)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // payload CRC, bit serial MSB first over 374 bits
    function automatic logic [9:0] ref_crc();
        logic [9:0] r = '0;
        for (int i = HDR; i <= CELL - 2; i++) begin
            for (int b = 7; b >= 0; b--) begin
                if (!(i == CELL - 2 && b < 2)) begin
                    logic top = r[9] ^ cell_in[i][b];
                    r = {r[8:0], 1'b0};
                    if (top) r = r ^ 10'h233;
                end
            end
        end
        return r;
    endfunction

    // remainder of the output payload plus check field
    function automatic logic [9:0] residue();
        logic [9:0] r = '0;
        for (int i = HDR; i < CELL; i++) begin
            for (int b = 7; b >= 0; b--) begin
                logic top = r[9] ^ cell_out[i][b];
                r = {r[8:0], 1'b0};
                if (top) r = r ^ 10'h233;
            end
        end
        return r;
    endfunction

    task automatic push(input logic [7:0] d, input logic soc, input logic en_first,
                        input bit wiggle_en, input logic [7:0] expd, input string req,
                        output logic [7:0] got);
        bit fired = 1'b0;
        while (!fired) begin
            @(negedge clk);
            in_valid  = ($urandom % 100) >= stall_pct;
            out_ready = ($urandom % 100) >= stall_pct;
            in_data   = d;
            in_soc    = soc;
            in_crc_en = (soc || !wiggle_en) ? en_first : 1'($urandom);
            #1;
            if (out_valid != in_valid || in_ready != out_ready || out_soc != in_soc)
                chk(1'b0, "R2", {out_valid, in_ready, out_soc}, {in_valid, out_ready, in_soc});
            if (in_valid && out_ready) begin
                chk(out_data == expd, req, out_data, expd);
                got   = out_data;
                fired = 1'b1;
            end
        end
    endtask

    // kind: 0 random, 1 zeros, 2 ones
    task automatic send_cell(input logic en, input int kind, input bit wiggle_en);
        logic [9:0] c;
        logic [7:0] e;
        string req;
        for (int i = 0; i < CELL; i++)
            cell_in[i] = (kind == 1) ? 8'h00 : (kind == 2) ? 8'hFF : 8'($urandom);
        c = ref_crc();
        for (int i = 0; i < CELL; i++) begin
            e = cell_in[i];
            if (i < HDR) req = "R3";
            else if (i < CELL - 2) req = "R4";
            else req = en ? "R5" : "R7";
            if (wiggle_en) req = "R8";
            if (en && i == CELL - 2) e = {cell_in[i][7:2], c[9:8]};
            if (en && i == CELL - 1) e = c[7:0];
            push(cell_in[i], i == 0, en, wiggle_en, e, req, cell_out[i]);
        end
        if (en) chk(residue() == 10'h0, "R6", residue(), 0);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] g;
        void'($urandom(32'h1c10_2024));
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
        in_data = '0; in_soc = 1'b0; in_crc_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R2 reset", out_valid, 0);
        rst_n = 1'b1;
        // R1: stray bytes in hunt pass unchanged
        for (int k = 0; k < 3; k++) push(8'hA5 ^ 8'(k), 1'b0, 1'b1, 1'b0, 8'hA5 ^ 8'(k), "R1", g);
        // directed corners
        send_cell(1'b1, 1, 1'b0);        // R6 zero payload
        send_cell(1'b1, 2, 1'b0);        // R5 ones payload
        send_cell(1'b0, 0, 1'b0);        // R7
        send_cell(1'b1, 0, 1'b1);        // R8 enable toggles mid-cell
        send_cell(1'b0, 0, 1'b1);        // R8 off stays off
        stall_pct = 0;                   // R10 back to back
        send_cell(1'b1, 0, 1'b0);
        send_cell(1'b1, 0, 1'b0);
        stall_pct = 70;                  // R9 heavy stalls
        send_cell(1'b1, 0, 1'b0);
        stall_pct = 25;
        for (int n = 0; n < 40; n++) send_cell(1'($urandom), 0, ($urandom % 4) == 0);
        @(negedge clk);
        in_valid = 1'b0;
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule